// File: doc/BRIEF.md
# Dual-Channel Audio Sample Queue with Shared Interrupt

This block buffers 8-bit audio samples for two playback channels (A and B). Each channel has a 1024-byte circular store with its own write pointer, read pointer and occupancy count. When the mode field selects streaming, a bus write pushes one byte into the selected channel. In any other mode the same write stores the byte at the address given on the bus and leaves the pointers alone. A consumer tick pops one sample from each channel. An empty channel delivers the silence code 0x80.

Each channel keeps two status bits. The level bit is refreshed after every accepted push or pop. The edge bit marks "just became full" on the push side and "just ran dry" on the pop side. Both channels pack their status bits into one 4-bit word that is cleared when it is read, and they drive one shared interrupt line. A small mode state machine (IDLE, STREAM, TABLE, SPARE) mirrors the 2-bit mode field. Its transitions are: any state to another state on a write of a different value, which flushes both channels; and a write of the same value back to the same state, which leaves the channels untouched. A clear command also flushes both channels.

Top module: `sfp_pair`

## Requirements
- R1: After reset both channels are empty, the status word is 0, irq is 0, both sample outputs read 0x80, smp_vld is 0, the mode is IDLE (0) and the half-level interrupt enable of both channels is 1.
- R2: With mode 1 (STREAM), wr_en pushes wr_data into the channel chosen by wr_chan (0 = A, 1 = B) at its write pointer, and the pointer wraps from 1023 to 0. In any other mode, wr_en stores wr_data at wr_addr of that channel with no change to its count or status. peek_data shows byte peek_addr of channel peek_chan.
- R3: pop_tick makes smp_a and smp_b show the oldest byte of each channel on the next cycle, in push order, with smp_vld high for that one cycle. An empty channel gives 0x80 and its pointers and count stay unchanged.
- R4: After every accepted push or pop, the channel's status bit 0 is 1 when its count is 511 or less and 0 otherwise.
- R5: When the half-level enable of a channel is 1, a push that brings its count to exactly 512 raises irq, and so does a pop that brings it to exactly 511. When the enable is 0, neither event raises irq. hie_we loads hie_val, where bit 0 is channel A and bit 1 is channel B.
- R6: A push that brings the count to 1023 sets status bit 1 of that channel and raises irq. A pop that brings the count to 0 does the same.
- R7: A push to a channel that holds 1024 bytes is dropped: the store, the count and the status are unchanged.
- R8: stat_data is {B bit1, B bit0, A bit1, A bit0}. A stat_rd clears all four bits and lowers irq on the next cycle. A status event in the same cycle as stat_rd survives the clear and keeps irq high.
- R9: A mode write with a value different from the current mode, or a ctl write with bit 7 set, empties both channels, clears the status and lowers irq. A mode write of the current value, or a ctl write with bit 7 clear, changes nothing.
- R10: A push and a pop accepted by the same channel in the same cycle leave its count unchanged. They raise no half, full or empty event, and they refresh status bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Sample or direct byte write strobe |
| wr_chan | input | 1 | Target channel of the write (0 = A, 1 = B) |
| wr_addr | input | 10 | Byte address used when not streaming |
| wr_data | input | 8 | Written byte |
| mode_we | input | 1 | Mode field write strobe |
| mode_val | input | 2 | New mode (1 = STREAM) |
| ctl_we | input | 1 | Control write strobe |
| ctl_val | input | 8 | Control value, bit 7 = flush both channels |
| hie_we | input | 1 | Half-level interrupt enable write strobe |
| hie_val | input | 2 | Enables, bit 0 = A, bit 1 = B |
| stat_rd | input | 1 | Status read strobe (clears the status) |
| stat_data | output | 4 | Packed status word |
| pop_tick | input | 1 | Consumer tick, pops one sample per channel |
| smp_a | output | 8 | Last sample delivered by channel A |
| smp_b | output | 8 | Last sample delivered by channel B |
| smp_vld | output | 1 | Samples refreshed by the previous tick |
| peek_chan | input | 1 | Channel for store inspection |
| peek_addr | input | 10 | Byte address for store inspection |
| peek_data | output | 8 | Stored byte at peek_addr |
| irq | output | 1 | Shared interrupt request |

## Verification
Two pairs of functions can collide in one cycle. The first pair is the status-clearing read and a pop that drains a channel. The bench raises stat_rd together with the pop that empties channel A, and it expects the word 0011 with irq still high afterwards rather than a clean zero. The second pair is a push and a pop on the same channel. The bench issues both while the channel holds 512 bytes and expects no interrupt. A single later pop must then produce the 511-crossing interrupt, which shows that the count did not move.

// File: rtl/sfp_pkg.sv
package sfp_pkg;
    typedef enum logic [1:0] {
        MD_IDLE   = 2'd0,
        MD_STREAM = 2'd1,
        MD_TABLE  = 2'd2,
        MD_SPARE  = 2'd3
    } mode_e;

    localparam logic [7:0] SILENCE   = 8'h80;
    localparam int         FLUSH_BIT = 7;
    localparam int         NCH       = 2;
endpackage

// File: rtl/sfp_ctrl.sv
module sfp_ctrl
    import sfp_pkg::*;
#(
    parameter int NUM_CH = NCH
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_we,
    input  logic [1:0]        mode_val,
    input  logic              ctl_we,
    input  logic [7:0]        ctl_val,
    input  logic              hie_we,
    input  logic [NUM_CH-1:0] hie_val,
    input  logic              stat_rd,
    input  logic [NUM_CH-1:0] evt,
    output logic [1:0]        mode_q,
    output logic              stream_mode,
    output logic              flush,
    output logic [NUM_CH-1:0] hie_q,
    output logic              irq
);
    mode_e state_q, state_d;
    logic  irq_q;

    always_comb begin
        state_d = state_q;
        if (mode_we) state_d = mode_e'(mode_val);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= MD_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        unique case (state_q)
            MD_IDLE:   stream_mode = 1'b0;
            MD_STREAM: stream_mode = 1'b1;
            MD_TABLE:  stream_mode = 1'b0;
            MD_SPARE:  stream_mode = 1'b0;
            default:   stream_mode = 1'b0;
        endcase
        flush = (mode_we && (mode_val != 2'(state_q)))
              || (ctl_we && ctl_val[FLUSH_BIT]);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hie_q <= '1;
            irq_q <= 1'b0;
        end else begin
            if (hie_we) hie_q <= hie_val;
            if (flush)        irq_q <= 1'b0;
            else if (|evt)    irq_q <= 1'b1;
            else if (stat_rd) irq_q <= 1'b0;
        end
    end

    assign mode_q = 2'(state_q);
    assign irq    = irq_q;
endmodule

// File: rtl/sfp_chan.sv
module sfp_chan
    import sfp_pkg::*;
#(
    parameter int DEPTH = 1024,
    parameter int DW    = 8,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic          push_req,
    input  logic          poke_req,
    input  logic [AW-1:0] poke_addr,
    input  logic [DW-1:0] din,
    input  logic          pop_req,
    input  logic          hie,
    input  logic          clr_stat,
    input  logic [AW-1:0] peek_addr,
    output logic [DW-1:0] peek_data,
    output logic [DW-1:0] smp,
    output logic [1:0]    stat,
    output logic          evt,
    output logic [CW-1:0] cnt
);
    localparam int HALF = DEPTH / 2;

    logic [DW-1:0] mem [DEPTH];
    logic [AW-1:0] wptr_q, rptr_q;
    logic [CW-1:0] cnt_q, cnt_d;
    logic [1:0]    stat_q, stat_d;
    logic [DW-1:0] smp_q;
    logic          push_ok, pop_ok, half_evt, edge_evt, solo_push, solo_pop;

    assign push_ok   = push_req && !flush && (cnt_q != CW'(DEPTH));
    assign pop_ok    = pop_req  && !flush && (cnt_q != '0);
    assign solo_push = push_ok && !pop_ok;
    assign solo_pop  = pop_ok && !push_ok;

    always_comb begin
        cnt_d = cnt_q;
        if (solo_push)     cnt_d = cnt_q + 1'b1;
        else if (solo_pop) cnt_d = cnt_q - 1'b1;
    end

    assign half_evt = hie && ((solo_push && cnt_d == CW'(HALF))
                           || (solo_pop  && cnt_d == CW'(HALF - 1)));
    assign edge_evt = (solo_push && cnt_d == CW'(DEPTH - 1))
                   || (solo_pop  && cnt_d == '0);

    always_comb begin
        stat_d = clr_stat ? 2'b00 : stat_q;
        if (push_ok || pop_ok) begin
            stat_d[0] = (cnt_d <= CW'(HALF - 1));
            stat_d[1] = stat_d[1] | edge_evt;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wptr_q <= '0;
            rptr_q <= '0;
            cnt_q  <= '0;
            stat_q <= '0;
        end else begin
            if (push_ok) wptr_q <= wptr_q + 1'b1;
            if (pop_ok)  rptr_q <= rptr_q + 1'b1;
            cnt_q  <= cnt_d;
            stat_q <= stat_d;
        end
    end

    always_ff @(posedge clk) begin
        if (push_ok)       mem[wptr_q]    <= din;
        else if (poke_req) mem[poke_addr] <= din;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)       smp_q <= SILENCE;
        else if (pop_req) smp_q <= pop_ok ? mem[rptr_q] : SILENCE;
    end

    assign peek_data = mem[peek_addr];
    assign smp       = smp_q;
    assign stat      = stat_q;
    assign evt       = half_evt || edge_evt;
    assign cnt       = cnt_q;
endmodule

// File: rtl/sfp_pair.sv
module sfp_pair
    import sfp_pkg::*;
#(
    parameter int DEPTH = 1024,
    parameter int DW    = 8,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic          wr_chan,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic          mode_we,
    input  logic [1:0]    mode_val,
    input  logic          ctl_we,
    input  logic [7:0]    ctl_val,
    input  logic          hie_we,
    input  logic [1:0]    hie_val,
    input  logic          stat_rd,
    output logic [3:0]    stat_data,
    input  logic          pop_tick,
    output logic [DW-1:0] smp_a,
    output logic [DW-1:0] smp_b,
    output logic          smp_vld,
    input  logic          peek_chan,
    input  logic [AW-1:0] peek_addr,
    output logic [DW-1:0] peek_data,
    output logic          irq
);
    logic [1:0]    mode_q;
    logic          stream_mode, flush;
    logic [1:0]    hie_q, evt_v;
    logic [1:0]    stat_v [NCH];
    logic [CW-1:0] cnt_v  [NCH];
    logic [DW-1:0] smp_v  [NCH];
    logic [DW-1:0] peek_v [NCH];
    logic [CW-1:0] cnt_a, cnt_b;
    logic          vld_q;

    sfp_ctrl #(.NUM_CH(NCH)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode_we    (mode_we),
        .mode_val   (mode_val),
        .ctl_we     (ctl_we),
        .ctl_val    (ctl_val),
        .hie_we     (hie_we),
        .hie_val    (hie_val),
        .stat_rd    (stat_rd),
        .evt        (evt_v),
        .mode_q     (mode_q),
        .stream_mode(stream_mode),
        .flush      (flush),
        .hie_q      (hie_q),
        .irq        (irq)
    );

    for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
        logic sel;
        assign sel = wr_en && (wr_chan == 1'(ch));
        sfp_chan #(.DEPTH(DEPTH), .DW(DW)) u_chan (
            .clk      (clk),
            .rst_n    (rst_n),
            .flush    (flush),
            .push_req (sel && stream_mode),
            .poke_req (sel && !stream_mode),
            .poke_addr(wr_addr),
            .din      (wr_data),
            .pop_req  (pop_tick),
            .hie      (hie_q[ch]),
            .clr_stat (stat_rd),
            .peek_addr(peek_addr),
            .peek_data(peek_v[ch]),
            .smp      (smp_v[ch]),
            .stat     (stat_v[ch]),
            .evt      (evt_v[ch]),
            .cnt      (cnt_v[ch])
        );
    end

    always_ff @(posedge clk) begin
        if (!rst_n) vld_q <= 1'b0;
        else        vld_q <= pop_tick;
    end

    assign stat_data = {stat_v[1], stat_v[0]};
    assign smp_a     = smp_v[0];
    assign smp_b     = smp_v[1];
    assign smp_vld   = vld_q;
    assign peek_data = peek_chan ? peek_v[1] : peek_v[0];
    assign cnt_a     = cnt_v[0];
    assign cnt_b     = cnt_v[1];
endmodule

// File: rtl/sfp_pair_chk.sv
module sfp_pair_chk #(
    parameter int DEPTH = 1024,
    localparam int CW   = $clog2(DEPTH) + 1
) (
    input logic          clk,
    input logic          rst_n,
    input logic          wr_en,
    input logic          wr_chan,
    input logic          pop_tick,
    input logic          stat_rd,
    input logic          mode_we,
    input logic          ctl_we,
    input logic [7:0]    ctl_val,
    input logic          irq,
    input logic [3:0]    stat_data,
    input logic [7:0]    smp_a,
    input logic [1:0]    mode_q,
    input logic [CW-1:0] cnt_a,
    input logic [CW-1:0] cnt_b
);
    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_a <= CW'(DEPTH)) && (cnt_b <= CW'(DEPTH))); // R7

    AST_DROP_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == 2'd1 && wr_en && !wr_chan && !pop_tick && !mode_we && !ctl_we
         && cnt_a == CW'(DEPTH)) |=> (cnt_a == CW'(DEPTH))); // R7

    AST_EMPTY_SILENCE: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_tick && cnt_a == '0) |=> (smp_a == 8'h80)); // R3

    AST_FULL_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == 2'd1 && wr_en && !wr_chan && !pop_tick && !mode_we && !ctl_we
         && cnt_a == CW'(DEPTH - 2)) |=> (irq && stat_data[1])); // R6

    AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_rd && !wr_en && !pop_tick) |=> (!irq && stat_data == 4'd0)); // R8

    AST_FLUSH_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_we && ctl_val[7]) |=> (!irq && stat_data == 4'd0 && cnt_a == '0 && cnt_b == '0)); // R9

    AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (cnt_a == $past(cnt_a) || cnt_a == $past(cnt_a) + 1'b1
                  || cnt_a + 1'b1 == $past(cnt_a) || cnt_a == '0)); // R10
endmodule

bind sfp_pair sfp_pair_chk #(.DEPTH(DEPTH)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_chan  (wr_chan),
    .pop_tick (pop_tick),
    .stat_rd  (stat_rd),
    .mode_we  (mode_we),
    .ctl_we   (ctl_we),
    .ctl_val  (ctl_val),
    .irq      (irq),
    .stat_data(stat_data),
    .smp_a    (smp_a),
    .mode_q   (mode_q),
    .cnt_a    (cnt_a),
    .cnt_b    (cnt_b)
);

// File: tb/sfp_pair_bench.sv
`timescale 1ns/1ps
module sfp_pair_bench;
    localparam int DEPTH = 1024;
    localparam int AW    = $clog2(DEPTH);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 0, wr_chan = 0;
    logic [AW-1:0] wr_addr = '0;
    logic [7:0]    wr_data = '0;
    logic          mode_we = 0;
    logic [1:0]    mode_val = '0;
    logic          ctl_we = 0;
    logic [7:0]    ctl_val = '0;
    logic          hie_we = 0;
    logic [1:0]    hie_val = '0;
    logic          stat_rd = 0;
    logic [3:0]    stat_data;
    logic          pop_tick = 0;
    logic [7:0]    smp_a, smp_b, peek_data;
    logic          smp_vld, irq;
    logic          peek_chan = 0;
    logic [AW-1:0] peek_addr = '0;

    int n_cmp = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    sfp_pair #(.DEPTH(DEPTH)) u_sfp_pair (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_chan(wr_chan),
        .wr_addr(wr_addr), .wr_data(wr_data), .mode_we(mode_we),
        .mode_val(mode_val), .ctl_we(ctl_we), .ctl_val(ctl_val),
        .hie_we(hie_we), .hie_val(hie_val), .stat_rd(stat_rd),
        .stat_data(stat_data), .pop_tick(pop_tick), .smp_a(smp_a),
        .smp_b(smp_b), .smp_vld(smp_vld), .peek_chan(peek_chan),
        .peek_addr(peek_addr), .peek_data(peek_data), .irq(irq)
    );

    function automatic logic [7:0] pat(input int i);
        return 8'((i * 37 + 11) % 256);
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
        wr_en = 0; pop_tick = 0; stat_rd = 0; mode_we = 0; ctl_we = 0; hie_we = 0;
    endtask

    task automatic push(input logic ch, input logic [7:0] d);
        wr_en = 1; wr_chan = ch; wr_data = d; tick();
    endtask

    task automatic pop();
        pop_tick = 1; tick();
    endtask

    task automatic rd_clear();
        stat_rd = 1; tick();
    endtask

    task automatic set_mode(input logic [1:0] m);
        mode_we = 1; mode_val = m; tick();
    endtask

    initial begin
        #(5.0 * 200000);
        n_bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        #1;
        chk("R1 status", stat_data, 0);
        chk("R1 irq", irq, 0);
        chk("R1 smp_a", smp_a, 8'h80);
        chk("R1 smp_b", smp_b, 8'h80);
        chk("R1 vld", smp_vld, 0);
        @(negedge clk);
        pop();
        chk("R3 vld pulse", smp_vld, 1);
        chk("R3 idle pop silence", smp_a, 8'h80);

        set_mode(2'd1);
        chk("R9 mode change quiet", {irq, stat_data}, 0);

        // fill channel A completely
        for (int i = 0; i < DEPTH; i++) begin
            push(0, pat(i));
            if (i + 1 == 511) begin
                chk("R4 half bit at 511", stat_data, 4'b0001);
                chk("R5 no irq below 512", irq, 0);
            end
            if (i + 1 == 512) begin
                chk("R5 half irq on push", irq, 1);
                chk("R4 half bit clear at 512", stat_data, 0);
                rd_clear();
                chk("R8 read lowers irq", irq, 0);
            end
            if (i + 1 == 1023) begin
                chk("R6 full flag", stat_data, 4'b0010);
                chk("R6 full irq", irq, 1);
                rd_clear();
                chk("R8 read clears", {irq, stat_data}, 0);
            end
        end
        chk("R6 no event at 1024", {irq, stat_data}, 0);
        push(0, 8'hEE);
        chk("R7 drop no status", {irq, stat_data}, 0);
        peek_chan = 0; peek_addr = '0; #1;
        chk("R7 slot 0 intact", peek_data, pat(0));
        peek_addr = AW'(DEPTH - 1); #1;
        chk("R2 last slot", peek_data, pat(DEPTH - 1));

        // drain channel A
        for (int i = 0; i < DEPTH; i++) begin
            pop_tick = 1;
            if (i == DEPTH - 1) stat_rd = 1;
            tick();
            chk("R3 order", smp_a, pat(i));
            if (i == 0) chk("R3 empty B silence", smp_b, 8'h80);
            if (i == 512) begin
                chk("R5 half irq on pop", irq, 1);
                chk("R4 half bit at 511", stat_data, 4'b0001);
                rd_clear();
            end
        end
        chk("R8 event survives read", stat_data, 4'b0011);
        chk("R6 empty irq", irq, 1);
        rd_clear();
        pop();
        chk("R3 empty pop", smp_a, 8'h80);
        push(0, 8'h3C);
        chk("R4 one entry", {irq, stat_data}, 5'b00001);
        pop();
        chk("R3 pointers held", smp_a, 8'h3C);
        chk("R6 dry again", {irq, stat_data}, 5'b10011);
        rd_clear();

        // flush paths
        push(0, 8'h01);
        push(1, 8'h02);
        chk("R8 layout", stat_data, 4'b0101);
        set_mode(2'd1);
        chk("R9 same mode keeps", stat_data, 4'b0101);
        ctl_we = 1; ctl_val = 8'h7F; tick();
        chk("R9 bit7 low keeps", stat_data, 4'b0101);
        ctl_we = 1; ctl_val = 8'h80; tick();
        chk("R9 clear cmd", {irq, stat_data}, 0);
        pop();
        chk("R9 A emptied", smp_a, 8'h80);
        chk("R9 B emptied", smp_b, 8'h80);
        push(1, 8'h09);
        set_mode(2'd2);
        chk("R9 mode change flush", stat_data, 0);
        pop();
        chk("R9 B flushed by mode", smp_b, 8'h80);
        wr_addr = AW'(5);
        push(1, 8'h5A);
        peek_chan = 1; peek_addr = AW'(5); #1;
        chk("R2 direct write", peek_data, 8'h5A);
        chk("R2 no count change", stat_data, 0);
        set_mode(2'd1);

        // half interrupt disabled on A
        hie_we = 1; hie_val = 2'b10; tick();
        for (int i = 0; i < 512; i++) push(0, pat(i));
        chk("R5 disabled no irq", irq, 0);
        chk("R4 bit0 at 512", stat_data, 0);
        hie_we = 1; hie_val = 2'b11; tick();

        // simultaneous push and pop at 512
        wr_en = 1; wr_chan = 0; wr_data = 8'h77; pop_tick = 1; tick();
        chk("R10 sample", smp_a, pat(0));
        chk("R10 no event", {irq, stat_data}, 0);
        pop();
        chk("R10 count held, 511 crossing", irq, 1);
        chk("R10 half bit", stat_data, 4'b0001);
        chk("R10 next sample", smp_a, pat(1));

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule